// File: doc/BRIEF.md
# Vector Memory Alignment and Access Check Unit

This unit sits between a vector load/store pipeline and a memory port one line (64 bytes) wide. It takes one vector access at a time over a valid/ready handshake and sends it on as one or two line requests. Before it sends anything, it decides whether the access is allowed.

Aligned loads and stores drop the low six address bits and touch exactly one line. An unaligned load at a non-zero line offset reads the lower line first and the upper line second. It then shifts the pair so that vector byte 0 is the byte at the exact address, in little-endian order. A masked store passes its per-byte enables to the port. An aligned store writes every byte of its line.

The page attributes for the addressed line and for the following line come with the request: read allowed, write allowed and device type. A translation-enable flag also comes with it. A failed check returns a fault response with zero data, and no memory request is made for that access.

Top module: `vec_align_perm`

## Requirements
- R1: For every operation, the line address driven on `mem_addr` is the request address with bits [5:0] cleared. A misaligned address alone never causes a fault.
- R2: An unaligned load (`req_op`=01) at a non-zero offset makes two reads: first the line at the cleared address, then the line 64 bytes above it (wrapping at 2^32). Response byte i equals the memory byte at request address + i, with byte 0 in bits [7:0].
- R3: An unaligned load at offset 0 makes one read only. It ignores the next line's attributes: a non-readable or device next line does not cause a fault.
- R4: A masked store (`req_op`=11) drives `mem_we`=1, `mem_be`=`req_ben` and `mem_wdata`=`req_wdata`. It needs the line's write permission even when `req_ben` is all zero. With permission, a zero-enable store is still issued.
- R5: An aligned store (`req_op`=10) drives all 64 byte enables high. Aligned loads (`req_op`=00) read one line and return it unchanged. Reads drive `mem_we`=0 and all enables high.
- R6: An access to a device-type line faults. This covers the addressed line, and also the next line when a two-line load uses it.
- R7: Any access made while `xlat_on`=0 faults.
- R8: A faulting access issues no memory request. It gives a response with `rsp_fault`=1 and `rsp_data`=0.
- R9: A two-line unaligned load whose next line is not readable faults, even if the first line is allowed.
- R10: `req_ready` is high only when the unit is idle. Each accepted request gets exactly one single-cycle `rsp_valid` pulse. A memory request held without `mem_ready` keeps its address.
- R11: Loads need read permission on the addressed line and stores need write permission on it. Stores do not need read permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and accepting |
| req_op | input | 2 | 00 aligned load, 01 unaligned load, 10 aligned store, 11 masked store |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 512 | Store data, byte 0 in bits [7:0] |
| req_ben | input | 64 | Byte enables for masked store |
| xlat_on | input | 1 | Address translation enabled |
| lo_rd_ok | input | 1 | Addressed line readable |
| lo_wr_ok | input | 1 | Addressed line writable |
| lo_dev | input | 1 | Addressed line is device memory |
| hi_rd_ok | input | 1 | Next line readable |
| hi_dev | input | 1 | Next line is device memory |
| mem_valid | output | 1 | Line request valid |
| mem_ready | input | 1 | Line request accepted |
| mem_we | output | 1 | Line request is a write |
| mem_addr | output | 32 | Line address |
| mem_be | output | 64 | Byte enables |
| mem_wdata | output | 512 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 512 | Read line data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Access faulted |
| rsp_data | output | 512 | Load result, zero otherwise |

## Verification
The hardest cases to reach are the ones where attributes for one line pass and attributes for the other line fail. Examples are a two-line load with a blocked upper line, or an offset-zero load with a bad upper line that must be ignored. The stimulus sets the two attribute sets separately for chosen offsets, including 0, 1 and 63, and a load that wraps past the top of the address space. Memory acceptance is stalled at random, so that held requests and the order of the two reads are exercised. Each line request and each response is compared with a behavioural model of the expected request list.

// File: rtl/vec_align_perm.sv
module vec_align_perm #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  input  logic [LINE_BYTES-1:0]   req_ben,
  input  logic                    xlat_on,
  input  logic                    lo_rd_ok,
  input  logic                    lo_wr_ok,
  input  logic                    lo_dev,
  input  logic                    hi_rd_ok,
  input  logic                    hi_dev,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES-1:0]   mem_be,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata,
  output logic                    rsp_valid,
  output logic                    rsp_fault,
  output logic [LINE_BYTES*8-1:0] rsp_data
);
  localparam int DW    = LINE_BYTES * 8;
  localparam int OFF_W = $clog2(LINE_BYTES);

  localparam logic [1:0] OP_ULOAD = 2'b01;
  localparam logic [1:0] OP_MSTORE = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1, S_RESP} st_t;
  st_t state;

  logic [1:0]            op_q;
  logic [ADDR_W-1:0]     base_q;
  logic [OFF_W-1:0]      off_q;
  logic                  two_q;
  logic                  fault_q;
  logic [LINE_BYTES-1:0] ben_q;
  logic [DW-1:0]         wdata_q;
  logic [DW-1:0]         lo_q;
  logic [DW-1:0]         data_q;

  wire              is_store = req_op[1];
  wire [OFF_W-1:0]  off_in   = req_addr[OFF_W-1:0];
  wire              two_in   = (req_op == OP_ULOAD) && (off_in != '0);
  wire              fault_in = !xlat_on || lo_dev
                             || (!is_store && !lo_rd_ok)
                             || (is_store && !lo_wr_ok)
                             || (two_in && (hi_dev || !hi_rd_ok));
  wire              accept   = req_valid && req_ready;

  logic [DW-1:0] rot;
  assign rot = DW'({mem_rdata, lo_q} >> {off_q, 3'b000});

  assign req_ready = (state == S_IDLE);
  assign mem_valid = (state == S_REQ0) || (state == S_REQ1);
  assign mem_we    = op_q[1];
  assign mem_addr  = base_q + ((state == S_REQ1) ? ADDR_W'(LINE_BYTES) : '0);
  assign mem_be    = (op_q == OP_MSTORE) ? ben_q : '1;
  assign mem_wdata = wdata_q;
  assign rsp_valid = (state == S_RESP);
  assign rsp_fault = fault_q;
  assign rsp_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      base_q  <= '0;
      off_q   <= '0;
      two_q   <= 1'b0;
      fault_q <= 1'b0;
      ben_q   <= '0;
      wdata_q <= '0;
      lo_q    <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= req_op;
          base_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          off_q   <= off_in;
          two_q   <= two_in;
          fault_q <= fault_in;
          ben_q   <= req_ben;
          wdata_q <= req_wdata;
          data_q  <= '0;
          state   <= fault_in ? S_RESP : S_REQ0;
        end
        S_REQ0: if (mem_ready) state <= op_q[1] ? S_RESP : S_WAIT0;
        S_WAIT0: if (mem_rvalid) begin
          if (two_q) begin
            lo_q  <= mem_rdata;
            state <= S_REQ1;
          end else begin
            data_q <= mem_rdata;
            state  <= S_RESP;
          end
        end
        S_REQ1: if (mem_ready) state <= S_WAIT1;
        S_WAIT1: if (mem_rvalid) begin
          data_q <= rot;
          state  <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module vec_align_perm_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    rsp_valid,
  input logic                    rsp_fault,
  input logic [LINE_BYTES*8-1:0] rsp_data
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R1
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[OFF_W-1:0] == '0);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R8
  fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_data == '0);
  // R10
  no_mem_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !rsp_valid);
endmodule

bind vec_align_perm vec_align_perm_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
);

// File: tb/vec_align_perm_bench.sv
module vec_align_perm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int DW = LB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [LB-1:0] req_ben = '0;
  logic xlat_on = 1'b1, lo_rd_ok = 1'b1, lo_wr_ok = 1'b1, lo_dev = 1'b0, hi_rd_ok = 1'b1, hi_dev = 1'b0;
  logic mem_valid, mem_ready = 1'b0, mem_we, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [LB-1:0] mem_be;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic rsp_valid, rsp_fault;
  logic [DW-1:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_align_perm u_vec_align_perm (.*);

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit rsp_seen = 1'b0;
  bit rd_pend = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  string cur_tag = "";

  logic [AW-1:0] q_addr[$];
  logic          q_we[$];
  logic [LB-1:0] q_be[$];
  logic [DW-1:0] q_wd[$];
  logic          exp_fault;
  logic [DW-1:0] exp_data;

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    for (int i = 0; i < LB; i++) r[i*8 +: 8] = mb(a + AW'(i));
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected memory request", DW'(mem_addr), '0);
        end else begin
          logic [AW-1:0] ea; logic ew; logic [LB-1:0] eb; logic [DW-1:0] ed;
          ea = q_addr.pop_front(); ew = q_we.pop_front();
          eb = q_be.pop_front(); ed = q_wd.pop_front();
          chk(mem_addr == ea, cur_tag, "mem_addr", DW'(mem_addr), DW'(ea));
          chk(mem_we == ew && mem_be == eb, cur_tag, "mem_we/mem_be",
              DW'({mem_we, mem_be}), DW'({ew, eb}));
          if (ew) chk(mem_wdata == ed, cur_tag, "mem_wdata", mem_wdata, ed);
        end
        if (!mem_we) begin
          rd_pend = 1'b1;
          rd_addr = mem_addr;
        end
      end
      if (rsp_valid) begin
        chk(q_addr.size() == 0, cur_tag, "missing memory requests", DW'(q_addr.size()), '0);
        chk(rsp_fault == exp_fault, cur_tag, "rsp_fault", DW'(rsp_fault), DW'(exp_fault));
        chk(rsp_data == exp_data, cur_tag, "rsp_data", rsp_data, exp_data);
        rsp_seen = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    mem_ready <= ($urandom_range(0, 3) != 0);
    if (rd_pend) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= line_of(rd_addr);
      rd_pend = 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic do_op(input string tag, input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [LB-1:0] ben, input logic [DW-1:0] wd, input logic xl,
                       input logic lrd, input logic lwr, input logic ldv,
                       input logic hrd, input logic hdv);
    logic [AW-1:0] base;
    logic two, st, f;
    @(negedge clk);
    cur_tag = tag;
    base = {addr[AW-1:6], 6'b0};
    st   = op[1];
    two  = (op == 2'b01) && (addr[5:0] != 0);
    f    = !xl || ldv || (!st && !lrd) || (st && !lwr) || (two && (hdv || !hrd));
    exp_fault = f;
    exp_data  = '0;
    if (!f) begin
      q_addr.push_back(base); q_we.push_back(st);
      q_be.push_back(op == 2'b11 ? ben : '1); q_wd.push_back(wd);
      if (two) begin
        q_addr.push_back(base + 32'd64); q_we.push_back(1'b0);
        q_be.push_back('1); q_wd.push_back('0);
      end
      if (!st) exp_data = line_of(op == 2'b01 ? addr : base);
    end
    req_op = op; req_addr = addr; req_ben = ben; req_wdata = wd;
    xlat_on = xl; lo_rd_ok = lrd; lo_wr_ok = lwr; lo_dev = ldv; hi_rd_ok = hrd; hi_dev = hdv;
    rsp_seen = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "req_ready while busy", DW'(req_ready), '0);
    while (!rsp_seen) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_valid && !rsp_valid, "R10", "reset state",
        DW'({req_ready, mem_valid, rsp_valid}), DW'(3'b100));
    do_op("R1", 2'b00, 32'h1000_0025, '0, '0, 1, 1, 0, 0, 0, 0);
    do_op("R5", 2'b10, 32'h2000_003F, '0, {16{32'hDEAD_BEEF}}, 1, 0, 1, 0, 0, 0);
    do_op("R2", 2'b01, 32'h3000_0025, '0, '0, 1, 1, 0, 0, 1, 0);
    do_op("R2", 2'b01, 32'h3000_007F, '0, '0, 1, 1, 0, 0, 1, 0);
    do_op("R2", 2'b01, 32'h3000_0101, '0, '0, 1, 1, 0, 0, 1, 0);
    do_op("R2", 2'b01, 32'hFFFF_FFF0, '0, '0, 1, 1, 0, 0, 1, 0);
    do_op("R3", 2'b01, 32'h4000_0040, '0, '0, 1, 1, 0, 0, 0, 1);
    do_op("R4", 2'b11, 32'h5000_0013, 64'hF0F0_0000_1234_8001, {16{32'h0102_0304}}, 1, 0, 1, 0, 0, 0);
    do_op("R4", 2'b11, 32'h5000_0080, '0, '0, 1, 1, 0, 0, 1, 0);
    do_op("R4", 2'b11, 32'h5000_00C0, '0, {16{32'hCAFE_F00D}}, 1, 0, 1, 0, 0, 0);
    do_op("R6", 2'b00, 32'h6000_0000, '0, '0, 1, 1, 1, 1, 1, 0);
    do_op("R6", 2'b01, 32'h6000_0008, '0, '0, 1, 1, 0, 0, 1, 1);
    do_op("R9", 2'b01, 32'h7000_0030, '0, '0, 1, 1, 0, 0, 0, 0);
    do_op("R7", 2'b10, 32'h8000_0000, '0, '1, 0, 1, 1, 0, 1, 0);
    do_op("R7", 2'b01, 32'h8000_0011, '0, '0, 0, 1, 1, 0, 1, 0);
    do_op("R8", 2'b10, 32'h9000_0000, '0, '1, 1, 1, 0, 0, 1, 0);
    do_op("R11", 2'b00, 32'hA000_0000, '0, '0, 1, 0, 1, 0, 1, 0);
    do_op("R11", 2'b10, 32'hA000_0040, '0, {16{32'h5A5A_0F0F}}, 1, 0, 1, 0, 0, 0);
    for (int n = 0; n < 60; n++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      op = 2'($urandom_range(0, 3));
      a  = $urandom;
      if (n % 5 == 0) a[5:0] = '0;
      do_op("R2/R6/R11 mix", op, a, {$urandom, $urandom}, {16{$urandom}},
            $urandom_range(0, 9) != 0, $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
            $urandom_range(0, 9) == 0, $urandom_range(0, 5) != 0, $urandom_range(0, 9) == 0);
    end
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule